// File: doc/BRIEF.md
# I2C Start/Stop Condition Monitor

This block watches the SCL and SDA lines of an I2C bus and reports the bus state to a multi-master controller. It brings both lines into the system clock domain through a short synchronizer chain. It then recognises the two framing conditions: a Start, where SDA falls while SCL stays high, and a Stop, where SDA rises while SCL stays high. Two status flags record which of these conditions came last. A derived bus-free output tells firmware when it may try to claim the bus.

A sticky interrupt request is raised on a Start, on a Stop and on a byte-complete strobe from the shift logic next to this block. Firmware clears it with a one-cycle pulse. A stop-only mode masks everything except Stop. With this mode, software that finds the bus busy can enable the mode and sleep until the bus is released. Disabling the module clears all of its state and stops detection.

Top module: `i2c_cond_monitor`

## Requirements
- R1: After reset, startSeen, stopSeen and irq are 0 and busFree is 1.
- R2: A Start (synchronized SDA goes 1 to 0 while synchronized SCL is 1 on both the old and new sample) sets startSeen to 1 and clears stopSeen to 0.
- R3: A Stop (synchronized SDA goes 0 to 1 while synchronized SCL is 1 on both the old and new sample) sets stopSeen to 1 and clears startSeen to 0.
- R4: An SDA change while SCL is low, or in the same sample in which SCL changes, leaves the flags and irq unchanged.
- R5: busFree is 1 when stopSeen is 1, or when startSeen and stopSeen are both 0; otherwise it is 0.
- R6: With stopOnly at 0, a Start, a Stop or a one-cycle byteDone pulse sets irq to 1.
- R7: irq stays at 1 until irqClear is pulsed. A clear pulse drops irq to 0 on the next clock. An event in the same cycle as the clear keeps irq at 1.
- R8: With stopOnly at 1, a Start and a byteDone pulse leave irq at 0, and a Stop sets irq to 1.
- R9: While enable is 0, startSeen, stopSeen and irq are held at 0, and no bus condition or byteDone has any effect. Asserting enable while SDA differs from its value before the disable does not produce a Start or a Stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Module enable; 0 clears and freezes the monitor |
| stopOnly | input | 1 | 1 = interrupt only on Stop |
| sclIn | input | 1 | Sampled SCL line level |
| sdaIn | input | 1 | Sampled SDA line level |
| byteDone | input | 1 | One-cycle strobe at the end of a transferred byte |
| irqClear | input | 1 | One-cycle strobe that clears irq |
| startSeen | output | 1 | Last condition seen was a Start |
| stopSeen | output | 1 | Last condition seen was a Stop |
| busFree | output | 1 | Bus may be claimed |
| irq | output | 1 | Sticky interrupt request |

## Verification
The hardest case to reach is the full matrix of line transitions from a clean starting point. A pair in which SCL and SDA change together must not count as a condition. Neither may a change made while SCL is low. Every one of these transitions also has to begin with the flags and irq cleared. The bench handles this by disabling the module and moving the lines to the starting pair, which cannot create an edge while the module is disabled. It then re-enables the module and clears irq. Only then does it apply the second pair, for all sixteen start/end combinations in both interrupt modes. A separate sequence pulls SDA low under a high SCL while the module is disabled, then re-enables it, to show that the change is not taken as a Start.

// File: rtl/i2c_mon_pkg.sv
package i2c_mon_pkg;

  // Strobes from the control module to the datapath, one cycle each
  typedef struct packed {
    logic clearAll;   // module disabled: zero flags and irq
    logic setStart;   // qualified Start condition
    logic setStop;    // qualified Stop condition
    logic raiseIrq;   // event that requests an interrupt
    logic dropIrq;    // firmware clear of the request
  } monStrobe_t;

endpackage

// File: rtl/i2c_mon_datapath.sv
module i2c_mon_datapath
  import i2c_mon_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  monStrobe_t strobe,
  output logic       rawStart,
  output logic       rawStop,
  output logic       startSeen,
  output logic       stopSeen,
  output logic       irq
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] sclPipe;
  logic [LAST:0] sdaPipe;
  logic          syncScl;
  logic          syncSda;
  logic          prevScl;
  logic          prevSda;

  // Synchronizer chains; an idle bus rests high
  generate
    if (SYNC_STAGES < 2) begin : g_badStages
      initial $error("SYNC_STAGES must be at least 2");
    end
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) begin
            sclPipe[0] <= 1'b1;
            sdaPipe[0] <= 1'b1;
          end else begin
            sclPipe[0] <= sclIn;
            sdaPipe[0] <= sdaIn;
          end
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) begin
            sclPipe[i] <= 1'b1;
            sdaPipe[i] <= 1'b1;
          end else begin
            sclPipe[i] <= sclPipe[i-1];
            sdaPipe[i] <= sdaPipe[i-1];
          end
        end
      end
    end
  endgenerate

  assign syncScl = sclPipe[LAST];
  assign syncSda = sdaPipe[LAST];

  // Previous samples track continuously, so re-enabling sees no stale edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevScl <= 1'b1;
      prevSda <= 1'b1;
    end else begin
      prevScl <= syncScl;
      prevSda <= syncSda;
    end
  end

  logic sclHeldHigh;
  assign sclHeldHigh = syncScl && prevScl;
  assign rawStart    = sclHeldHigh && prevSda && !syncSda;
  assign rawStop     = sclHeldHigh && !prevSda && syncSda;

  // Status flags: each one marks the most recent condition
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startSeen <= 1'b0;
      stopSeen  <= 1'b0;
    end else if (strobe.clearAll) begin
      startSeen <= 1'b0;
      stopSeen  <= 1'b0;
    end else if (strobe.setStop) begin
      startSeen <= 1'b0;
      stopSeen  <= 1'b1;
    end else if (strobe.setStart) begin
      startSeen <= 1'b1;
      stopSeen  <= 1'b0;
    end
  end

  // Sticky request; a new event beats a clear in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irq <= 1'b0;
    end else if (strobe.clearAll) begin
      irq <= 1'b0;
    end else if (strobe.raiseIrq) begin
      irq <= 1'b1;
    end else if (strobe.dropIrq) begin
      irq <= 1'b0;
    end
  end

  assert_start_flags_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setStart && !strobe.clearAll |=> startSeen && !stopSeen);

  assert_stop_flags_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setStop && !strobe.clearAll |=> stopSeen && !startSeen);

  assert_flags_exclusive_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(startSeen && stopSeen));

  assert_irq_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    irq && !strobe.dropIrq && !strobe.clearAll |=> irq);

  assert_event_beats_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.raiseIrq && strobe.dropIrq && !strobe.clearAll |=> irq);

  assert_no_cond_scl_low_R4: assert property (@(posedge clk) disable iff (!rstN)
    !syncScl |-> !rawStart && !rawStop);

endmodule

// File: rtl/i2c_mon_control.sv
module i2c_mon_control
  import i2c_mon_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       stopOnly,
  input  logic       byteDone,
  input  logic       irqClear,
  input  logic       rawStart,
  input  logic       rawStop,
  output monStrobe_t strobe
);

  logic anyEvent;
  assign anyEvent = rawStop || (!stopOnly && (rawStart || byteDone));

  always_comb begin
    strobe          = '0;
    strobe.clearAll = !enable;
    strobe.setStart = enable && rawStart;
    strobe.setStop  = enable && rawStop;
    strobe.raiseIrq = enable && anyEvent;
    strobe.dropIrq  = irqClear;
  end

  assert_stop_only_mask_R8: assert property (@(posedge clk) disable iff (!rstN)
    stopOnly && strobe.raiseIrq |-> rawStop);

  assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> !strobe.setStart && !strobe.setStop && !strobe.raiseIrq);

endmodule

// File: rtl/i2c_cond_monitor.sv
module i2c_cond_monitor
  import i2c_mon_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic enable,
  input  logic stopOnly,
  input  logic sclIn,
  input  logic sdaIn,
  input  logic byteDone,
  input  logic irqClear,
  output logic startSeen,
  output logic stopSeen,
  output logic busFree,
  output logic irq
);

  monStrobe_t strobe;
  logic       rawStart;
  logic       rawStop;

  i2c_mon_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .sclIn     (sclIn),
    .sdaIn     (sdaIn),
    .strobe    (strobe),
    .rawStart  (rawStart),
    .rawStop   (rawStop),
    .startSeen (startSeen),
    .stopSeen  (stopSeen),
    .irq       (irq)
  );

  i2c_mon_control u_control (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (enable),
    .stopOnly (stopOnly),
    .byteDone (byteDone),
    .irqClear (irqClear),
    .rawStart (rawStart),
    .rawStop  (rawStop),
    .strobe   (strobe)
  );

  assign busFree = stopSeen || (!startSeen && !stopSeen);

  assert_disable_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !startSeen && !stopSeen && !irq);

  assert_busy_after_start_R5: assert property (@(posedge clk) disable iff (!rstN)
    startSeen |-> !busFree);

endmodule

// File: tb/i2c_cond_monitor_tb.sv
`timescale 1ns/1ps
module i2c_cond_monitor_tb;

  localparam real CLK_PERIOD = 20.0;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic stopOnly = 1'b0;
  logic sclIn = 1'b1;
  logic sdaIn = 1'b1;
  logic byteDone = 1'b0;
  logic irqClear = 1'b0;
  logic startSeen, stopSeen, busFree, irq;

  int checkCount = 0;
  int failCount = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_cond_monitor u_dut (
    .clk(clk), .rstN(rstN), .enable(enable), .stopOnly(stopOnly),
    .sclIn(sclIn), .sdaIn(sdaIn), .byteDone(byteDone), .irqClear(irqClear),
    .startSeen(startSeen), .stopSeen(stopSeen), .busFree(busFree), .irq(irq)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic pulseClear();
    irqClear = 1'b1; tick(1); irqClear = 1'b0; tick(1);
  endtask

  task automatic pulseByte();
    byteDone = 1'b1; tick(1); byteDone = 1'b0; tick(1);
  endtask

  // Drive both lines, then let the synchronizer and flag registers settle
  task automatic setLines(input logic scl, input logic sda);
    sclIn = scl; sdaIn = sda; tick(4);
  endtask

  initial begin
    tick(3);
    check("R1", "startSeen", startSeen, 1'b0);
    check("R1", "stopSeen", stopSeen, 1'b0);
    check("R1", "irq", irq, 1'b0);
    check("R1", "busFree", busFree, 1'b1);
    rstN = 1'b1;
    tick(2);

    // Sweep every (scl,sda) start pair to every end pair, both irq modes
    for (int mode = 0; mode < 2; mode++) begin
      for (int a = 0; a < 4; a++) begin
        for (int b = 0; b < 4; b++) begin
          logic aScl, aSda, bScl, bSda, expStart, expStop, expIrq;
          aScl = a[1]; aSda = a[0]; bScl = b[1]; bSda = b[0];
          stopOnly = mode[0];
          enable = 1'b0;
          setLines(aScl, aSda);
          enable = 1'b1;
          tick(2);
          pulseClear();
          setLines(bScl, bSda);
          expStart = aScl && bScl && aSda && !bSda;
          expStop  = aScl && bScl && !aSda && bSda;
          expIrq   = expStop || (!stopOnly && expStart);
          check(expStart ? "R2" : (expStop ? "R3" : "R4"), "startSeen", startSeen, expStart);
          check(expStart ? "R2" : (expStop ? "R3" : "R4"), "stopSeen", stopSeen, expStop);
          check(stopOnly ? "R8" : "R6", "irq", irq, expIrq);
          check("R5", "busFree", busFree, expStop || !expStart);
        end
      end
    end

    // byteDone in both modes
    stopOnly = 1'b0; enable = 1'b1;
    setLines(1'b1, 1'b1);
    pulseClear();
    pulseByte();
    check("R6", "irq after byteDone", irq, 1'b1);
    pulseClear();
    check("R7", "irq after clear", irq, 1'b0);
    stopOnly = 1'b1;
    pulseByte();
    check("R8", "irq after byteDone in stopOnly", irq, 1'b0);

    // Stop-only: Start ignored, Stop raises
    setLines(1'b1, 1'b0);
    check("R8", "irq after Start in stopOnly", irq, 1'b0);
    check("R2", "startSeen in stopOnly", startSeen, 1'b1);
    check("R5", "busFree while busy", busFree, 1'b0);
    setLines(1'b1, 1'b1);
    check("R8", "irq after Stop in stopOnly", irq, 1'b1);
    check("R5", "busFree after Stop", busFree, 1'b1);

    // Sticky and clear priority
    stopOnly = 1'b0;
    tick(6);
    check("R7", "irq held", irq, 1'b1);
    irqClear = 1'b1; byteDone = 1'b1; tick(1);
    irqClear = 1'b0; byteDone = 1'b0; tick(1);
    check("R7", "event beats clear", irq, 1'b1);
    pulseClear();
    check("R7", "irq cleared", irq, 1'b0);

    // Disable behaviour
    setLines(1'b1, 1'b0);
    check("R2", "startSeen before disable", startSeen, 1'b1);
    enable = 1'b0; tick(1);
    check("R9", "startSeen disabled", startSeen, 1'b0);
    check("R9", "irq disabled", irq, 1'b0);
    setLines(1'b1, 1'b1);
    check("R9", "Stop ignored while disabled", stopSeen, 1'b0);
    pulseByte();
    check("R9", "byteDone ignored while disabled", irq, 1'b0);
    setLines(1'b1, 1'b0);
    check("R9", "Start ignored while disabled", startSeen, 1'b0);
    enable = 1'b1; tick(4);
    check("R9", "no Start on re-enable", startSeen, 1'b0);
    check("R9", "no irq on re-enable", irq, 1'b0);
    setLines(1'b1, 1'b1);
    check("R3", "Stop after re-enable", stopSeen, 1'b1);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checkCount, failCount);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checkCount++;
      failCount++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checkCount, failCount);
      $finish;
    end
  end

endmodule